// File: doc/BRIEF.md
# Circuit Emulation Playout Buffer

This block is the egress jitter buffer of one circuit emulation channel. Payload bytes taken from received cells are written into it in bursts. A line-rate strobe reads them out at a constant pace. Between a low mark and a high mark, the buffer absorbs the variation in cell arrival delay. The low mark sets the minimum playout delay and comes from the channel's delay-variation setting, given in bytes. The high mark is the configured buffer size.

When the buffer starves, the block sends the filler byte 0xFF on every read. It then refills silently up to the low mark before playout resumes. When a write would push the fill past the buffer size, the block records an overflow. It then drops every incoming byte until reads have drained the fill back down to the low mark. Two saturating counters are exported: one counts filler bytes played and one counts bytes dropped.

The write side is a valid/ready stream that never applies back-pressure. `in_ready` is held high, so a byte offered with `in_valid` is always taken in that cycle, either stored or dropped and counted. The read side has no handshake. Each cycle with `rd_strobe` high consumes one byte, and the byte is presented on `rd_data` in that same cycle.

Top module: `cep_playout_buffer`

## Requirements
- R1: After reset the controller is in the filling state. Both counters are zero, both event outputs are low, and a read returns 0xFF.
- R2: In the filling state every read returns 0xFF and adds one to the filler counter. No stored byte is consumed, even when some are held.
- R3: Once the registered fill level is at or above the effective low mark, playout starts at the next clock edge. From then on, reads return the stored bytes in write order.
- R4: A read during playout with an empty buffer returns 0xFF and adds one to the filler counter. It raises `underflow_pulse` for exactly one cycle, in the cycle after the read, and returns the controller to the filling state, which then needs a refill to the low mark.
- R5: During playout, a write is an overflow when the fill already equals the effective size and no read happens in that cycle. The byte is dropped and counted, `overflow_pulse` goes high for exactly one cycle in the cycle after the write, and the controller enters the discard state.
- R6: In the discard state every offered byte is dropped and counted, while reads keep returning stored bytes in order. Once the registered fill is at or below the low mark, playout resumes at the next edge and writes are stored again.
- R7: Both counters stop at their all-ones value, 2^CNT_W-1.
- R8: `in_ready` is high in every cycle.
- R9: The effective size is `cfg_size` capped at DEPTH. The effective low mark is `cfg_cdv_bytes` capped at the effective size, so a low setting above the size still lets playout start once the buffer is full.
- R10: During playout, a write and a read in the same cycle at full fill both take place. The write is stored, with no overflow and no drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write byte offered |
| in_data | input | 8 | Write byte |
| in_ready | output | 1 | Always high; the block never stalls the writer |
| rd_strobe | input | 1 | Line-rate read request |
| rd_data | output | 8 | Byte played in the strobe cycle (0xFF when filler) |
| cfg_size | input | $clog2(DEPTH+1) | Buffer size in bytes (high mark) |
| cfg_cdv_bytes | input | $clog2(DEPTH+1) | Delay-variation setting in bytes (low mark) |
| underflow_pulse | output | 1 | One-cycle pulse on entry to refill after starvation |
| overflow_pulse | output | 1 | One-cycle pulse on entry to discard |
| filler_count | output | CNT_W | Saturating count of filler bytes played |
| drop_count | output | CNT_W | Saturating count of bytes dropped |

## Verification
The bench reads while the buffer is still filling and already holds some bytes. A design that played early would return real data where 0xFF is expected. After a starvation, it refills only part of the way, so a design that resumed on the first byte instead of the low mark would be caught. It overflows and then offers bytes while reads drain the buffer. A design that accepted writes as soon as room appeared, and not only at the low mark, would put extra bytes into the played sequence and undercount drops. The bench also checks the full-fill cycle with a simultaneous read and write, where a false overflow would appear. It checks a low setting above the size, where a missing cap would keep the channel filling forever, and it checks counter saturation.

// File: rtl/cep_pkg.sv
package cep_pkg;
  typedef enum logic [1:0] {
    PB_FILL = 2'd0,
    PB_PLAY = 2'd1,
    PB_DROP = 2'd2
  } pb_state_t;

  localparam logic [7:0] PB_FILLER_BYTE = 8'hFF;
endpackage

// File: rtl/pb_store.sv
module pb_store #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0]     mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    if (p == ADDR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/pb_satcnt.sv
module pb_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/pb_ctrl.sv
module pb_ctrl
  import cep_pkg::*;
#(
  parameter int FILL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              rd_strobe,
  input  logic [FILL_W-1:0] size_eff,
  input  logic [FILL_W-1:0] low_eff,
  output logic              wr_en,
  output logic              pop,
  output logic              filler_ev,
  output logic              drop_ev,
  output logic              uf_pulse,
  output logic              of_pulse,
  output pb_state_t         state,
  output logic [FILL_W-1:0] fill
);
  pb_state_t         state_nx;
  logic [FILL_W-1:0] fill_after_pop;
  logic              has_data;
  logic              uf_ev;
  logic              of_ev;

  assign has_data       = (fill != '0);
  assign pop            = rd_strobe && (state != PB_FILL) && has_data;
  assign filler_ev      = rd_strobe && !pop;
  assign fill_after_pop = fill - FILL_W'(pop);

  always_comb begin
    wr_en    = 1'b0;
    uf_ev    = 1'b0;
    of_ev    = 1'b0;
    state_nx = state;
    unique case (state)
      PB_FILL: begin
        wr_en = in_valid && (fill < size_eff);
        if (fill >= low_eff) state_nx = PB_PLAY;
      end
      PB_PLAY: begin
        wr_en = in_valid && (fill_after_pop < size_eff);
        of_ev = in_valid && !(fill_after_pop < size_eff);
        uf_ev = rd_strobe && !has_data;
        if (uf_ev)      state_nx = PB_FILL;
        else if (of_ev) state_nx = PB_DROP;
      end
      PB_DROP: begin
        wr_en = 1'b0;
        if (fill <= low_eff) state_nx = PB_PLAY;
      end
      default: state_nx = PB_FILL;
    endcase
  end

  assign drop_ev = in_valid && !wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PB_FILL;
      fill     <= '0;
      uf_pulse <= 1'b0;
      of_pulse <= 1'b0;
    end else begin
      state    <= state_nx;
      fill     <= fill_after_pop + FILL_W'(wr_en);
      uf_pulse <= uf_ev;
      of_pulse <= of_ev;
    end
  end
endmodule

// File: rtl/cep_playout_buffer.sv
module cep_playout_buffer
  import cep_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CNT_W = 16,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              rd_strobe,
  output logic [7:0]        rd_data,
  input  logic [FILL_W-1:0] cfg_size,
  input  logic [FILL_W-1:0] cfg_cdv_bytes,
  output logic              underflow_pulse,
  output logic              overflow_pulse,
  output logic [CNT_W-1:0]  filler_count,
  output logic [CNT_W-1:0]  drop_count
);
  localparam int NCNT = 2;

  logic [FILL_W-1:0] size_eff;
  logic [FILL_W-1:0] low_eff;
  logic              wr_en;
  logic              pop;
  logic              filler_ev;
  logic              drop_ev;
  pb_state_t         state;
  logic [FILL_W-1:0] fill;
  logic [7:0]        mem_q;
  logic [NCNT-1:0]   cnt_inc;
  logic [CNT_W-1:0]  cnt_val [NCNT];

  assign size_eff = (cfg_size > FILL_W'(DEPTH)) ? FILL_W'(DEPTH) : cfg_size;
  assign low_eff  = (cfg_cdv_bytes > size_eff) ? size_eff : cfg_cdv_bytes;
  assign in_ready = 1'b1;

  pb_ctrl #(.FILL_W(FILL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .rd_strobe (rd_strobe),
    .size_eff  (size_eff),
    .low_eff   (low_eff),
    .wr_en     (wr_en),
    .pop       (pop),
    .filler_ev (filler_ev),
    .drop_ev   (drop_ev),
    .uf_pulse  (underflow_pulse),
    .of_pulse  (overflow_pulse),
    .state     (state),
    .fill      (fill)
  );

  pb_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (in_data),
    .rd_en   (pop),
    .rd_data (mem_q)
  );

  assign rd_data = pop ? mem_q : PB_FILLER_BYTE;

  assign cnt_inc[0] = filler_ev;
  assign cnt_inc[1] = drop_ev;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    pb_satcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .count (cnt_val[g])
    );
  end

  assign filler_count = cnt_val[0];
  assign drop_count   = cnt_val[1];
endmodule

// File: rtl/pb_checker.sv
module pb_checker
  import cep_pkg::*;
#(
  parameter int FILL_W = 10,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              rd_strobe,
  input logic [7:0]        rd_data,
  input logic              underflow_pulse,
  input logic              overflow_pulse,
  input logic [CNT_W-1:0]  filler_count,
  input logic [CNT_W-1:0]  drop_count,
  input pb_state_t         state,
  input logic [FILL_W-1:0] fill,
  input logic [FILL_W-1:0] size_eff
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_FILL_SENDS_FILLER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PB_FILL && rd_strobe) |-> rd_data == 8'hFF); // R2

  AST_UF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_pulse |=> !underflow_pulse); // R4

  AST_UF_TO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_pulse |-> state == PB_FILL); // R4

  AST_OF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_pulse |=> !overflow_pulse); // R5

  AST_OF_TO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_pulse |-> state == PB_DROP); // R5

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= size_eff); // R5

  AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PB_DROP && in_valid && drop_count != TOP) |=> drop_count == $past(drop_count) + 1'b1); // R6

  AST_FILLER_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (filler_count == TOP) |=> filler_count == TOP); // R7
endmodule

bind cep_playout_buffer pb_checker #(.FILL_W(FILL_W), .CNT_W(CNT_W)) u_pb_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .rd_strobe       (rd_strobe),
  .rd_data         (rd_data),
  .underflow_pulse (underflow_pulse),
  .overflow_pulse  (overflow_pulse),
  .filler_count    (filler_count),
  .drop_count      (drop_count),
  .state           (state),
  .fill            (fill),
  .size_eff        (size_eff)
);

// File: tb/test_cep_playout_buffer.sv
module test_cep_playout_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int CNT_W  = 8;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [7:0]        in_data = '0;
  logic              in_ready;
  logic              rd_strobe = 1'b0;
  logic [7:0]        rd_data;
  logic [FILL_W-1:0] cfg_size = '0;
  logic [FILL_W-1:0] cfg_cdv_bytes = '0;
  logic              underflow_pulse;
  logic              overflow_pulse;
  logic [CNT_W-1:0]  filler_count;
  logic [CNT_W-1:0]  drop_count;

  int checks = 0;
  int errors = 0;
  logic [7:0] r;
  logic uf, of;

  always #(CLK_PERIOD/2) clk = ~clk;

  cep_playout_buffer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_cep_playout_buffer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .cfg_size(cfg_size), .cfg_cdv_bytes(cfg_cdv_bytes),
    .underflow_pulse(underflow_pulse), .overflow_pulse(overflow_pulse),
    .filler_count(filler_count), .drop_count(drop_count)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, capture rd_data before the edge, pulses after it.
  task automatic cyc(input logic wv, input logic [7:0] wd, input logic rs,
                     output logic [7:0] rdv, output logic ufo, output logic ofo);
    @(negedge clk);
    in_valid = wv; in_data = wd; rd_strobe = rs;
    #1 rdv = rd_data;
    @(posedge clk);
    #1 ufo = underflow_pulse; ofo = overflow_pulse;
    in_valid = 1'b0; rd_strobe = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    cyc(1'b1, d, 1'b0, r, uf, of);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, r, uf, of);
  endtask

  task automatic do_reset(input int size, input int low);
    @(negedge clk);
    rst_n = 1'b0; cfg_size = FILL_W'(size); cfg_cdv_bytes = FILL_W'(low);
    in_valid = 1'b0; rd_strobe = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(16, 4);
    #1;
    chk("R1 filler_count", 32'(filler_count), 0);
    chk("R1 drop_count", 32'(drop_count), 0);
    chk("R1 pulses", {30'd0, underflow_pulse, overflow_pulse}, 0);
    chk("R8 in_ready", 32'(in_ready), 1);
    cyc(1'b0, 8'h00, 1'b1, r, uf, of);
    chk("R1 first read filler", 32'(r), 32'hFF);
  endtask

  task automatic t_fill_and_play;
    do_reset(16, 4);
    cyc(1'b0, 8'h00, 1'b1, r, uf, of); chk("R2 read empty", 32'(r), 32'hFF);
    wr(8'h01);
    cyc(1'b0, 8'h00, 1'b1, r, uf, of); chk("R2 read holding 1", 32'(r), 32'hFF);
    wr(8'h02); wr(8'h03);
    cyc(1'b0, 8'h00, 1'b1, r, uf, of); chk("R2 read holding 3", 32'(r), 32'hFF);
    chk("R2 filler_count", 32'(filler_count), 3);
    wr(8'h04);
    chk("R8 in_ready busy", 32'(in_ready), 1);
    idle(2);
    for (int i = 1; i <= 4; i++) begin
      cyc(1'b0, 8'h00, 1'b1, r, uf, of);
      chk("R3 play order", 32'(r), 32'(i));
    end
    chk("R3 no filler during play", 32'(filler_count), 3);
  endtask

  task automatic t_underflow;
    do_reset(16, 4);
    for (int i = 0; i < 4; i++) wr(8'h50 + 8'(i));
    idle(2);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 8'h00, 1'b1, r, uf, of);
      chk("R3 data", 32'(r), 32'h50 + 32'(i));
    end
    cyc(1'b0, 8'h00, 1'b1, r, uf, of);
    chk("R4 starved read", 32'(r), 32'hFF);
    chk("R4 underflow pulse", 32'(uf), 1);
    idle(1);
    chk("R4 pulse one cycle", 32'(uf), 0);
    wr(8'h60); wr(8'h61);
    cyc(1'b0, 8'h00, 1'b1, r, uf, of);
    chk("R4 no resume below low", 32'(r), 32'hFF);
    wr(8'h62); wr(8'h63);
    idle(2);
    cyc(1'b0, 8'h00, 1'b1, r, uf, of);
    chk("R4 resume after refill", 32'(r), 32'h60);
    chk("R4 filler_count", 32'(filler_count), 2);
  endtask

  task automatic t_overflow;
    do_reset(8, 4);
    for (int i = 0; i < 4; i++) wr(8'h10 + 8'(i));
    idle(2);
    for (int i = 4; i < 8; i++) wr(8'h10 + 8'(i));
    chk("R5 no drop at full", 32'(drop_count), 0);
    cyc(1'b1, 8'h99, 1'b0, r, uf, of);
    chk("R5 overflow pulse", 32'(of), 1);
    chk("R5 drop counted", 32'(drop_count), 1);
    cyc(1'b1, 8'h98, 1'b1, r, uf, of);
    chk("R5 pulse one cycle", 32'(of), 0);
    chk("R6 read during discard", 32'(r), 32'h10);
    chk("R6 write dropped with room", 32'(drop_count), 2);
    for (int i = 1; i < 4; i++) begin
      cyc(1'b0, 8'h00, 1'b1, r, uf, of);
      chk("R6 drain order", 32'(r), 32'h10 + 32'(i));
    end
    idle(1);
    wr(8'h20);
    chk("R6 write accepted after drain", 32'(drop_count), 2);
    for (int i = 4; i < 8; i++) begin
      cyc(1'b0, 8'h00, 1'b1, r, uf, of);
      chk("R6 remaining order", 32'(r), 32'h10 + 32'(i));
    end
    cyc(1'b0, 8'h00, 1'b1, r, uf, of);
    chk("R6 resumed byte", 32'(r), 32'h20);
  endtask

  task automatic t_simul_full;
    do_reset(8, 4);
    for (int i = 0; i < 4; i++) wr(8'h30 + 8'(i));
    idle(2);
    for (int i = 4; i < 8; i++) wr(8'h30 + 8'(i));
    cyc(1'b1, 8'h40, 1'b1, r, uf, of);
    chk("R10 read at full", 32'(r), 32'h30);
    chk("R10 no overflow", 32'(of), 0);
    chk("R10 no drop", 32'(drop_count), 0);
    for (int i = 1; i < 8; i++) begin
      cyc(1'b0, 8'h00, 1'b1, r, uf, of);
      chk("R10 order", 32'(r), 32'h30 + 32'(i));
    end
    cyc(1'b0, 8'h00, 1'b1, r, uf, of);
    chk("R10 stored byte", 32'(r), 32'h40);
  endtask

  task automatic t_low_cap;
    do_reset(6, 20);
    for (int i = 0; i < 6; i++) wr(8'h70 + 8'(i));
    idle(2);
    cyc(1'b0, 8'h00, 1'b1, r, uf, of);
    chk("R9 low capped to size", 32'(r), 32'h70);
  endtask

  task automatic t_saturate;
    do_reset(16, 4);
    for (int i = 0; i < 300; i++) cyc(1'b0, 8'h00, 1'b1, r, uf, of);
    chk("R7 filler saturates", 32'(filler_count), 32'hFF);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_and_play();
    t_underflow();
    t_overflow();
    t_simul_full();
    t_low_cap();
    t_saturate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule